// File: doc/BRIEF.md
# Serial EEPROM Slave on a Two-Wire Bus

This block is a two-wire (I2C) bus slave that fronts a 256-byte store held in flip-flops. A fast system clock samples SCL and SDA through synchronizers. The block recognises START, repeated START and STOP conditions and decodes a 7-bit device address plus a direction bit. It keeps a word-address counter and answers byte writes, four-byte page writes, current-address reads and sequential reads. A random read is a write header that loads the counter, followed by a repeated START in read direction.

SDA is never driven high. The block asserts `sda_oe` to pull the line low for acknowledge bits and for data bits of value 0. The system wires SDA as `sda_i = pad & ~sda_oe`. Written bytes are held in a page buffer and move into the store only when STOP arrives.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset `sda_oe` is 0, and every location of the store reads back as FFh until it is written.
- R2: An SDA fall while SCL is high (START) starts a new device-address phase from any state. An SDA rise while SCL is high (STOP) returns the block to idle with SDA released.
- R3: The block acknowledges (SDA low on the ninth clock) only a device byte whose upper seven bits are 1010 followed by `dev_sel[2:0]`, with the direction in bit 0 (0 = write, 1 = read). On a mismatch it gives no acknowledge and does not drive the bus until the next START or STOP.
- R4: In a write, the word-address byte and every data byte are acknowledged. The data reaches the store only on STOP; a START that arrives before STOP throws the buffered bytes away.
- R5: After each written data byte only the two low bits of the counter advance. A fifth byte therefore lands on the first location written and overwrites it.
- R6: After a byte at address n is read or written, the counter holds n+1. A read header with no word address returns the byte at the counter.
- R7: A write header that carries only a word address, followed by a repeated START in read direction, returns the byte at that word address.
- R8: When the master acknowledges a read byte, the next byte follows from the incremented counter, wrapping from 255 to 0.
- R9: A master NACK, or a STOP in place of the ninth clock, ends a read and leaves SDA released.
- R10: Read data leaves MSB first, and `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND result) |
| dev_sel | input | 3 | Low three bits of the device address, from pins |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Every bus event is seen three system clocks after the pad changes: two synchronizer flops plus the edge register. `sda_oe` therefore moves three clocks after the SCL fall that calls for it. The bench holds each SCL phase for six system clocks and reads SDA in the middle of the high phase and again near its end. In that way a driven bit is always settled when it is sampled, and any change during the high phase shows up. Stored data is checked only after STOP has reached the store, by reading it back over the bus, against a model computed from the address.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_WADDR,
      ST_WADDR_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RD_ACK,
      ST_IGNORE
   } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
   parameter int PAGE_BYTES = 4,
   parameter int LANE_W     = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    wr_en,
   input  logic [LANE_W-1:0]       wr_lane,
   input  logic [7:0]              wr_data,
   output logic [PAGE_BYTES-1:0]   lane_vld,
   output logic [PAGE_BYTES*8-1:0] lane_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane_vld  <= '0;
         lane_data <= '0;
      end else if (clear) begin
         lane_vld <= '0;
      end else if (wr_en) begin
         lane_vld[wr_lane]                  <= 1'b1;
         lane_data[{wr_lane, 3'b000} +: 8]  <= wr_data;
      end
   end
endmodule

// File: rtl/eeprom_cell_array.sv
module eeprom_cell_array #(
   parameter int DEPTH      = 256,
   parameter int AW         = 8,
   parameter int PAGE_BYTES = 4,
   parameter int LANE_W     = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    commit,
   input  logic [AW-LANE_W-1:0]    page_hi,
   input  logic [PAGE_BYTES-1:0]   lane_vld,
   input  logic [PAGE_BYTES*8-1:0] lane_data,
   input  logic [AW-1:0]           rd_addr,
   output logic [7:0]              rd_data
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      end else if (commit) begin
         for (int l = 0; l < PAGE_BYTES; l++) begin
            if (lane_vld[l]) mem[{page_hi, LANE_W'(l)}] <= lane_data[l*8 +: 8];
         end
      end
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
   import eeprom_slave_pkg::*;
#(
   parameter int         MEM_DEPTH   = 256,
   parameter int         PAGE_BYTES  = 4,
   parameter logic [3:0] DEV_PREFIX  = 4'b1010,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] dev_sel,
   output logic       sda_oe
);
   localparam int AW     = $clog2(MEM_DEPTH);
   localparam int LANE_W = $clog2(PAGE_BYTES);

   generate
      if (MEM_DEPTH != (1 << AW) || MEM_DEPTH > 256) begin : g_bad_depth
         $error("i2c_eeprom_slave: MEM_DEPTH must be a power of two up to 256");
      end
      if (PAGE_BYTES != (1 << LANE_W) || PAGE_BYTES < 2 || PAGE_BYTES >= MEM_DEPTH) begin : g_bad_page
         $error("i2c_eeprom_slave: PAGE_BYTES must be a power of two below MEM_DEPTH");
      end
   endgenerate

   logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   slv_state_e state;
   logic [2:0] bitcnt;
   logic [7:0] shreg;
   logic [AW-1:0] cnt;
   logic       is_read, got8, mack;
   logic       wr_strobe, rd_adv, addr_hit;
   logic [7:0] rd_data;
   logic [PAGE_BYTES-1:0]   lane_vld;
   logic [PAGE_BYTES*8-1:0] lane_data;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   assign addr_hit  = (shreg[7:1] == {DEV_PREFIX, dev_sel});
   assign wr_strobe = (state == ST_WDATA) && scl_fall && got8 && !start_det && !stop_det;
   assign rd_adv    = (state == ST_RDATA) && scl_rise && (bitcnt == 3'd7) && !start_det && !stop_det;

   eeprom_page_buf #(.PAGE_BYTES(PAGE_BYTES), .LANE_W(LANE_W)) u_pbuf (
      .clk(clk), .rst_n(rst_n), .clear(start_det | stop_det),
      .wr_en(wr_strobe), .wr_lane(cnt[LANE_W-1:0]), .wr_data(shreg),
      .lane_vld(lane_vld), .lane_data(lane_data)
   );

   eeprom_cell_array #(.DEPTH(MEM_DEPTH), .AW(AW), .PAGE_BYTES(PAGE_BYTES), .LANE_W(LANE_W)) u_array (
      .clk(clk), .rst_n(rst_n), .commit(stop_det), .page_hi(cnt[AW-1:LANE_W]),
      .lane_vld(lane_vld), .lane_data(lane_data), .rd_addr(cnt), .rd_data(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bitcnt  <= '0;
         shreg   <= '0;
         cnt     <= '0;
         is_read <= 1'b0;
         got8    <= 1'b0;
         mack    <= 1'b0;
         sda_oe  <= 1'b0;
      end else if (start_det || stop_det) begin
         state  <= start_det ? ST_DEV : ST_IDLE;
         bitcnt <= '0;
         got8   <= 1'b0;
         mack   <= 1'b0;
         sda_oe <= 1'b0;
      end else begin
         case (state)
            ST_DEV, ST_WADDR, ST_WDATA: begin
               if (scl_rise) begin
                  shreg  <= {shreg[6:0], sda_s};
                  bitcnt <= bitcnt + 3'd1;
                  if (bitcnt == 3'd7) got8 <= 1'b1;
               end else if (scl_fall && got8) begin
                  got8 <= 1'b0;
                  if (state == ST_DEV) begin
                     if (addr_hit) begin
                        is_read <= shreg[0];
                        sda_oe  <= 1'b1;
                        state   <= ST_DEV_ACK;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_IGNORE;
                     end
                  end else if (state == ST_WADDR) begin
                     cnt    <= shreg[AW-1:0];
                     sda_oe <= 1'b1;
                     state  <= ST_WADDR_ACK;
                  end else begin
                     cnt    <= {cnt[AW-1:LANE_W], cnt[LANE_W-1:0] + 1'b1};
                     sda_oe <= 1'b1;
                     state  <= ST_WDATA_ACK;
                  end
               end
            end
            ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
               if (scl_fall) begin
                  bitcnt <= '0;
                  if (state == ST_DEV_ACK && is_read) begin
                     shreg  <= rd_data;
                     sda_oe <= ~rd_data[7];
                     state  <= ST_RDATA;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= (state == ST_DEV_ACK) ? ST_WADDR : ST_WDATA;
                  end
               end
            end
            ST_RDATA: begin
               if (scl_rise) begin
                  bitcnt <= bitcnt + 3'd1;
                  if (rd_adv) begin
                     got8 <= 1'b1;
                     cnt  <= cnt + 1'b1;
                  end
               end else if (scl_fall) begin
                  if (got8) begin
                     got8   <= 1'b0;
                     sda_oe <= 1'b0;
                     state  <= ST_RD_ACK;
                  end else begin
                     shreg  <= {shreg[6:0], 1'b0};
                     sda_oe <= ~shreg[6];
                  end
               end
            end
            ST_RD_ACK: begin
               if (scl_rise) begin
                  if (sda_s) state <= ST_IGNORE;
                  else       mack  <= 1'b1;
               end else if (scl_fall && mack) begin
                  mack   <= 1'b0;
                  bitcnt <= '0;
                  shreg  <= rd_data;
                  sda_oe <= ~rd_data[7];
                  state  <= ST_RDATA;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/eeprom_slave_chk.sv
module eeprom_slave_chk
   import eeprom_slave_pkg::*;
#(
   parameter int AW     = 8,
   parameter int LANE_W = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl_s,
   input logic          start_det,
   input logic          stop_det,
   input logic          wr_strobe,
   input logic          rd_adv,
   input logic          sda_oe,
   input slv_state_e    state,
   input logic [AW-1:0] cnt
);
   // R10
   oe_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   // R2
   stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_oe && state == ST_IDLE));

   // R2
   start_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (!sda_oe && state == ST_DEV));

   // R5
   page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |=> (cnt == {$past(cnt[AW-1:LANE_W]), LANE_W'($past(cnt[LANE_W-1:0]) + 1'b1)}));

   // R8
   seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_adv |=> (cnt == AW'($past(cnt) + 1'b1)));

   // R3
   ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IGNORE) |-> !sda_oe);
endmodule

bind i2c_eeprom_slave eeprom_slave_chk #(.AW(AW), .LANE_W(LANE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det), .stop_det(stop_det),
   .wr_strobe(wr_strobe), .rd_adv(rd_adv), .sda_oe(sda_oe), .state(state), .cnt(cnt)
);

// File: tb/test_i2c_eeprom_slave.sv
module test_i2c_eeprom_slave;
   localparam int H = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic [2:0] pins = 3'b101;
   logic       sda_oe;
   logic       sda_bus;
   logic [7:0] model [256];
   int         vec = 0;
   int         bad = 0;
   bit         done = 1'b0;

   assign sda_bus = sda_m & ~sda_oe;

   always #4 clk = ~clk;

   i2c_eeprom_slave i_i2c_eeprom_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
      .dev_sel(pins), .sda_oe(sda_oe)
   );

   function automatic logic [7:0] pat(int a);
      return 8'((a * 37 + 11) & 255);
   endfunction

   task automatic hw(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(string tag, int act, int exp);
      vec++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; hw(H);
      scl = 1'b1;   hw(H);
      sda_m = 1'b0; hw(H);
      scl = 1'b0;   hw(H);
   endtask

   task automatic bus_stop();
      scl = 1'b0;   sda_m = 1'b0; hw(H);
      scl = 1'b1;   hw(H);
      sda_m = 1'b1; hw(2 * H);
   endtask

   task automatic send_byte(logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; hw(H);
         scl = 1'b1;   hw(H);
         scl = 1'b0;
      end
      sda_m = 1'b1; hw(H);
      scl = 1'b1;   hw(H / 2);
      ack = ~sda_bus;
      hw(H - H / 2);
      scl = 1'b0;
   endtask

   // mode: 0 master ACK, 1 master NACK, 2 no ninth clock
   task automatic recv_byte(int mode, string tag, output logic [7:0] b);
      logic late;
      bit   steady = 1'b1;
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         hw(H);
         scl = 1'b1; hw(H / 2);
         b[i] = sda_bus;
         hw(H / 2 - 1);
         late = sda_bus;
         if (late != b[i]) steady = 1'b0;
         hw(1);
         scl = 1'b0;
      end
      check({tag, " R10 data steady while SCL high"}, int'(steady), 1);
      if (mode != 2) begin
         sda_m = (mode == 0) ? 1'b0 : 1'b1; hw(H);
         scl = 1'b1; hw(H);
         scl = 1'b0;
         sda_m = 1'b1;
      end
   endtask

   function automatic logic [7:0] dev(logic rw, logic [2:0] sel);
      return {4'b1010, sel, rw};
   endfunction

   // random read of n bytes from addr, last byte ended by given mode, then STOP
   task automatic rand_read(int addr, int n, int last_mode, string tag);
      logic       ack;
      logic [7:0] b;
      bus_start();
      send_byte(dev(1'b0, pins), ack); check({tag, " R3 device ack"}, int'(ack), 1);
      send_byte(8'(addr), ack);        check({tag, " R4 word address ack"}, int'(ack), 1);
      bus_start();
      send_byte(dev(1'b1, pins), ack); check({tag, " R7 read header ack"}, int'(ack), 1);
      for (int k = 0; k < n; k++) begin
         recv_byte((k == n - 1) ? last_mode : 0, tag, b);
         check({tag, " R7 R8 byte"}, int'(b), int'(model[(addr + k) & 255]));
      end
      bus_stop();
      check({tag, " R9 SDA released"}, int'(sda_oe), 0);
   endtask

   initial begin : wd
      repeat (190000) @(posedge clk);
      if (!done) begin
         vec++; bad++;
         $display("FAIL watchdog: got 0 expected 1 (run completed)");
         $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
         $finish;
      end
   end

   initial begin : main
      logic       ack;
      logic [7:0] b;
      logic [7:0] d [5];
      for (int a = 0; a < 256; a++) model[a] = 8'hFF;
      hw(5);
      check("R1 sda_oe after reset", int'(sda_oe), 0);
      rst_n = 1'b1;
      hw(5);
      check("R1 sda_oe idle", int'(sda_oe), 0);

      // R1: erased contents
      rand_read(8'h80, 4, 1, "erased");

      // R4: full sweep of page writes
      for (int p = 0; p < 64; p++) begin
         bus_start();
         send_byte(dev(1'b0, pins), ack); check("sweep R3 ack", int'(ack), 1);
         send_byte(8'(p * 4), ack);       check("sweep R4 addr ack", int'(ack), 1);
         for (int k = 0; k < 4; k++) begin
            send_byte(pat(p * 4 + k), ack); check("sweep R4 data ack", int'(ack), 1);
            model[p * 4 + k] = pat(p * 4 + k);
         end
         bus_stop();
      end

      // R8: read all 256 plus one, wrapping 255 -> 0; counter ends at 1
      rand_read(0, 257, 1, "sweep");

      // R6: current-address read, ended by STOP without ninth clock
      bus_start();
      send_byte(dev(1'b1, pins), ack); check("cur R6 ack", int'(ack), 1);
      recv_byte(2, "cur", b);
      check("cur R6 byte at counter", int'(b), int'(model[1]));
      bus_stop();
      check("cur R9 released after STOP", int'(sda_oe), 0);

      // R5: five bytes into page 40h starting at 41h
      for (int k = 0; k < 5; k++) d[k] = 8'(8'hC0 + k * 5);
      bus_start();
      send_byte(dev(1'b0, pins), ack); check("page R3 ack", int'(ack), 1);
      send_byte(8'h41, ack);           check("page R4 addr ack", int'(ack), 1);
      for (int k = 0; k < 5; k++) begin
         send_byte(d[k], ack); check("page R4 data ack", int'(ack), 1);
         model[8'h40 | ((1 + k) & 3)] = d[k];
      end
      bus_stop();
      bus_start();
      send_byte(dev(1'b1, pins), ack); check("page R6 ack", int'(ack), 1);
      recv_byte(1, "page", b);
      check("page R5 R6 counter after wrap", int'(b), int'(model[8'h42]));
      bus_stop();
      rand_read(8'h40, 4, 1, "page R5");

      // R3: wrong device address is not acknowledged and has no effect
      bus_start();
      send_byte(dev(1'b0, pins ^ 3'b001), ack); check("miss R3 no ack", int'(ack), 0);
      send_byte(8'h20, ack);                    check("miss R3 addr ignored", int'(ack), 0);
      send_byte(8'h55, ack);                    check("miss R3 data ignored", int'(ack), 0);
      bus_stop();
      rand_read(8'h20, 1, 1, "miss R3 unchanged");

      // R4, R2: START before STOP discards buffered byte; counter moved to 31h
      bus_start();
      send_byte(dev(1'b0, pins), ack); check("abort R3 ack", int'(ack), 1);
      send_byte(8'h30, ack);           check("abort R4 addr ack", int'(ack), 1);
      send_byte(8'h5A, ack);           check("abort R4 data ack", int'(ack), 1);
      bus_start();
      send_byte(dev(1'b1, pins), ack); check("abort R2 restart ack", int'(ack), 1);
      recv_byte(1, "abort", b);
      check("abort R6 counter n+1", int'(b), int'(model[8'h31]));
      check("abort R9 released after NACK", int'(sda_oe), 0);
      bus_stop();
      rand_read(8'h30, 1, 1, "abort R4 discarded");

      // R8: sequential wrap from FEh
      rand_read(8'hFE, 4, 1, "wrap R8");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end
endmodule